// File: doc/BRIEF.md
# Buffered Compare Timer with Toggle Output

This block is an up-counting timer that advances once per clock cycle in which its `tick` enable is high. Software programs two compare values through a small write port. The period value sets how many ticks make up one run. The match value sets one extra compare point inside that run. The counter never compares against the written registers directly. Each value first passes through a shadow buffer, and a control bit chooses when that buffer reloads: either at once on every write, or only when the period ends and when software issues a counter clear.

On every match compare the output pin inverts. A clear loads the pin with a programmable starting level. The timer has two modes. In periodic mode the counter wraps and keeps running. In one-shot mode it runs a single period and then drops its own enable. Each match hit and each period hit raises a one-cycle strobe.

The write port decodes `wr_addr` as follows: 0 is the period register, 1 is the match register and 2 is control. A control write sets these bits from `wr_data`: bit 0 enable, bit 1 clear (it acts only in the cycle it is written), bit 2 update-always, bit 3 start level and bit 4 one-shot.

Top module: `tgl_timer`

## Requirements
- R1: After reset the pin is low and both strobes are low. No strobe appears until the timer has been configured and enabled.
- R2: When the period buffer holds N > 0 and the timer is enabled in periodic mode, `irq_period` pulses once every N ticks. The count starts at the clear. The pulse appears in the cycle after the clock edge that took the N-th tick, and the counter then restarts from zero.
- R3: When the match buffer holds M with 0 < M <= N, `irq_match` pulses on the M-th tick of each period and the pin inverts at that same edge, so successive inversions are N ticks apart.
- R4: When the match buffer holds zero, `irq_match` never pulses and the pin keeps its level.
- R5: When the match value equals the period value, the pin inversion and `irq_match` fall in the same cycle as `irq_period`, which is the counter restart.
- R6: When the period buffer holds zero, setting enable does not start counting. No strobe fires and the pin does not move.
- R7: With update-always (control bit 2) clear, a write to the period or match register changes nothing until the next period hit or clear write. At that point the buffer takes the register value.
- R8: With update-always set, a period or match write reaches its buffer at the next clock edge and is used from the next tick onward.
- R9: A control write with clear (bit 1) set zeroes the counter, reloads both buffers and drives the pin to the start-level bit (bit 3) of that same write.
- R10: In one-shot mode (control bit 4) the timer stops after the first period hit and clears its enable. A further clear-and-enable write runs exactly one more period.
- R11: Cycles with `tick` low neither advance the counter nor produce strobes.
- R12: A clear write takes priority over a `tick` in the same cycle. That tick is discarded and the next period is a full N ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 period, 1 match, 2 control |
| wr_data | input | 16 | Write data |
| tick | input | 1 | Count enable, one tick per high cycle |
| pin_out | output | 1 | Toggling output |
| irq_match | output | 1 | One-cycle match strobe |
| irq_period | output | 1 | One-cycle period strobe |

## Verification
The hardest case to bring about is one where a register write lands in the middle of a period. The only evidence of the reload policy is the tick count that follows, up to the next period strobe. To reach it, the stimulus starts a long period, spends a few ticks, rewrites the period to a shorter value, and then counts ticks to the next strobe and to the one after it. It does this once with immediate reload and once with deferred reload. The zero-period and zero-match cases run through a full stretch of ticks and check that no strobe and no pin movement appears. A clear write is also placed on the same cycle as a tick, to show that the tick is lost.

// File: rtl/tgl_timer_pkg.sv
package tgl_timer_pkg;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_PERIOD = 2'd0;
    localparam logic [ADDR_W-1:0] A_MATCH  = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;

    localparam int B_EN   = 0;
    localparam int B_CLR  = 1;
    localparam int B_UA   = 2;
    localparam int B_LVL  = 3;
    localparam int B_ONE  = 4;

    typedef struct packed {
        logic en;
        logic ua;
        logic lvl;
        logic one;
        logic pin;
        logic irq_m;
        logic irq_p;
    } ctl_t;
endpackage

// File: rtl/tgl_shadow.sv
module tgl_shadow #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] src_next,
    input  logic         src_wr,
    input  logic         imm,
    input  logic         reload,
    output logic [W-1:0] buf_q
);
    logic [W-1:0] buf_d;

    always_comb begin
        buf_d = buf_q;
        if (reload || (imm && src_wr)) begin
            buf_d = src_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end
endmodule

// File: rtl/tgl_count.sv
module tgl_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         run,
    input  logic         clear,
    input  logic [W-1:0] per_buf,
    input  logic [W-1:0] mat_buf,
    output logic         per_hit,
    output logic         mat_hit,
    output logic [W-1:0] cnt_q
);
    logic [W-1:0] cnt_d;
    logic [W-1:0] nxt;
    logic         step;

    always_comb begin
        nxt     = cnt_q + 1'b1;
        step    = tick && run && !clear;
        per_hit = step && (nxt == per_buf);
        mat_hit = step && (mat_buf != '0) && (nxt == mat_buf);
        cnt_d   = cnt_q;
        if (clear || per_hit) cnt_d = '0;
        else if (step)        cnt_d = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tgl_timer.sv
module tgl_timer
    import tgl_timer_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic              tick,
    output logic              pin_out,
    output logic              irq_match,
    output logic              irq_period
);
    localparam int NBUF = 2;

    ctl_t         st_d, st_q;
    logic [W-1:0] per_d, per_q, mat_d, mat_q;
    logic         per_wr, mat_wr, ctl_wr, clr_wr;
    logic         per_hit, mat_hit, run, ua_q;
    logic [W-1:0] per_buf, mat_buf, cnt_q;

    logic [NBUF-1:0][W-1:0] src_next, buf_q;
    logic [NBUF-1:0]        src_wr;

    always_comb begin
        per_wr = wr_en && (wr_addr == A_PERIOD);
        mat_wr = wr_en && (wr_addr == A_MATCH);
        ctl_wr = wr_en && (wr_addr == A_CTRL);
        clr_wr = ctl_wr && wr_data[B_CLR];
        run    = st_q.en && (per_buf != '0);
        ua_q   = st_q.ua;

        per_d = per_wr ? wr_data : per_q;
        mat_d = mat_wr ? wr_data : mat_q;

        st_d = st_q;
        if (ctl_wr) begin
            st_d.en  = wr_data[B_EN];
            st_d.ua  = wr_data[B_UA];
            st_d.lvl = wr_data[B_LVL];
            st_d.one = wr_data[B_ONE];
        end else if (per_hit && st_q.one) begin
            st_d.en = 1'b0;
        end
        if (clr_wr)       st_d.pin = wr_data[B_LVL];
        else if (mat_hit) st_d.pin = ~st_q.pin;
        st_d.irq_m = mat_hit;
        st_d.irq_p = per_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= '0;
            per_q <= '0;
            mat_q <= '0;
        end else begin
            st_q  <= st_d;
            per_q <= per_d;
            mat_q <= mat_d;
        end
    end

    assign src_next[0] = per_d;
    assign src_next[1] = mat_d;
    assign src_wr[0]   = per_wr;
    assign src_wr[1]   = mat_wr;

    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        tgl_shadow #(.W(W)) u_shadow (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_next (src_next[i]),
            .src_wr   (src_wr[i]),
            .imm      (st_q.ua),
            .reload   (clr_wr || per_hit),
            .buf_q    (buf_q[i])
        );
    end

    assign per_buf = buf_q[0];
    assign mat_buf = buf_q[1];

    tgl_count #(.W(W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (run),
        .clear   (clr_wr),
        .per_buf (per_buf),
        .mat_buf (mat_buf),
        .per_hit (per_hit),
        .mat_hit (mat_hit),
        .cnt_q   (cnt_q)
    );

    assign pin_out    = st_q.pin;
    assign irq_match  = st_q.irq_m;
    assign irq_period = st_q.irq_p;
endmodule

// File: rtl/tgl_timer_chk.sv
module tgl_timer_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr_wr,
    input logic         per_wr,
    input logic [W-1:0] wr_data,
    input logic         ua_q,
    input logic         pin_out,
    input logic         irq_match,
    input logic         irq_period,
    input logic [W-1:0] per_buf,
    input logic [W-1:0] mat_buf,
    input logic [W-1:0] cnt_q
);
    // R2: a period hit always leaves the counter at its start value
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_period |-> (cnt_q == '0));

    // R3: every match strobe comes with a pin inversion
    p_match_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_match |-> (pin_out != $past(pin_out)));

    // R4: the pin moves only on a match or a clear
    p_pin_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out != $past(pin_out)) |-> (irq_match || $past(clr_wr)));

    // R4: a zero match buffer never yields a match strobe
    p_zero_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mat_buf) == '0) |-> !irq_match);

    // R6: a zero period buffer never yields a period strobe
    p_zero_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(per_buf) == '0) |-> !irq_period);

    // R7: with deferred reload the period buffer holds between reload events
    p_defer_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ua_q) && !$past(clr_wr) && !irq_period) |-> $stable(per_buf));

    // R8: with immediate reload the buffer follows the written value
    p_imm_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ua_q) && $past(per_wr)) |-> (per_buf == $past(wr_data)));
endmodule

bind tgl_timer tgl_timer_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_wr     (clr_wr),
    .per_wr     (per_wr),
    .wr_data    (wr_data),
    .ua_q       (ua_q),
    .pin_out    (pin_out),
    .irq_match  (irq_match),
    .irq_period (irq_period),
    .per_buf    (per_buf),
    .mat_buf    (mat_buf),
    .cnt_q      (cnt_q)
);

// File: tb/tgl_timer_tb.sv
module tgl_timer_tb;
    localparam int CLK_P = 10;
    localparam int W     = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic         tick = 1'b0;
    logic         pin_out, irq_match, irq_period;

    tgl_timer #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tick(tick), .pin_out(pin_out),
        .irq_match(irq_match), .irq_period(irq_period)
    );

    always #(CLK_P/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural reference state
    int m_per = 0, m_mat = 0, m_pbuf = 0, m_mbuf = 0, m_cnt = 0;
    bit m_en = 0, m_ua = 0, m_sl = 0, m_os = 0, m_pin = 0, m_im = 0, m_ip = 0;

    // observed event tallies
    int obs_ip = 0, obs_im = 0, obs_tog = 0, obs_both = 0;
    bit last_ip = 0, last_im = 0, prev_pin = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input bit we, input int a, input int d, input bit t);
        bit clr, run, hit, ph, mh;
        int nx, nper, nmat;
        @(negedge clk);
        wr_en = we; wr_addr = a[1:0]; wr_data = d[W-1:0]; tick = t;
        clr  = we && a == 2 && d[1];
        run  = m_en && m_pbuf != 0;
        hit  = t && run && !clr;
        nx   = (m_cnt + 1) % 65536;
        ph   = hit && nx == m_pbuf;
        mh   = hit && m_mbuf != 0 && nx == m_mbuf;
        nper = (we && a == 0) ? d : m_per;
        nmat = (we && a == 1) ? d : m_mat;
        if (clr || ph)                 m_pbuf = nper;
        else if (m_ua && we && a == 0) m_pbuf = d;
        if (clr || ph)                 m_mbuf = nmat;
        else if (m_ua && we && a == 1) m_mbuf = d;
        if (clr || ph)   m_cnt = 0;
        else if (hit)    m_cnt = nx;
        if (clr)         m_pin = d[3];
        else if (mh)     m_pin = !m_pin;
        if (we && a == 2) begin
            m_en = d[0]; m_ua = d[2]; m_sl = d[3]; m_os = d[4];
        end else if (ph && m_os) begin
            m_en = 0;
        end
        m_im = mh; m_ip = ph; m_per = nper; m_mat = nmat;
        @(posedge clk);
        #1;
        chk(pin_out == m_pin && irq_match == m_im && irq_period == m_ip,
            "R2 R3 cycle model {pin,im,ip}",
            {29'd0, pin_out, irq_match, irq_period}, {29'd0, m_pin, m_im, m_ip});
        last_ip = irq_period; last_im = irq_match;
        if (irq_period) obs_ip++;
        if (irq_match)  obs_im++;
        if (irq_period && irq_match) obs_both++;
        if (pin_out != prev_pin) obs_tog++;
        prev_pin = pin_out;
        wr_en = 0; tick = 0;
    endtask

    task automatic wreg(input int a, input int d);
        step(1, a, d, 0);
    endtask

    task automatic ctrl(input bit en, input bit clr, input bit ua, input bit sl, input bit os);
        step(1, 2, {27'd0, os, sl, ua, clr, en}, 0);
    endtask

    task automatic clear_obs();
        obs_ip = 0; obs_im = 0; obs_tog = 0; obs_both = 0;
    endtask

    task automatic run_ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            step(0, 0, 0, 1);
            for (int g = 0; g < gap; g++) step(0, 0, 0, 0);
        end
    endtask

    task automatic wait_evt(input bit sel_match, input int limit, output int k);
        k = 0;
        while (k < limit) begin
            step(0, 0, 0, 1);
            k++;
            if (sel_match ? last_im : last_ip) break;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step(0, 0, 0, 1);
        step(0, 0, 0, 1);
        chk(pin_out == 0, "R1 pin after reset", pin_out, 0);
        chk(!irq_match && !irq_period, "R1 strobes after reset", irq_match + irq_period, 0);

        // periodic, period 5, match 2
        wreg(0, 5); wreg(1, 2);
        ctrl(1, 1, 0, 0, 0);
        clear_obs();
        run_ticks(20, 0);
        chk(obs_ip == 4, "R2 period strobes in 20 ticks", obs_ip, 4);
        chk(obs_im == 4, "R3 match strobes in 20 ticks", obs_im, 4);
        chk(obs_tog == 4, "R3 pin toggles in 20 ticks", obs_tog, 4);
        ctrl(1, 1, 0, 0, 0);
        wait_evt(1, 50, k);
        chk(k == 2, "R3 ticks to first match", k, 2);
        wait_evt(1, 50, k);
        chk(k == 5, "R3 ticks between matches", k, 5);

        // sparse ticks
        ctrl(1, 1, 0, 0, 0);
        clear_obs();
        run_ticks(10, 3);
        chk(obs_ip == 2, "R11 period strobes with gapped ticks", obs_ip, 2);
        chk(obs_tog == 2, "R11 toggles with gapped ticks", obs_tog, 2);

        // zero match
        wreg(1, 0);
        ctrl(1, 1, 0, 1, 0);
        clear_obs();
        run_ticks(12, 0);
        chk(obs_im == 0, "R4 match strobes with zero match", obs_im, 0);
        chk(obs_tog == 0, "R4 toggles with zero match", obs_tog, 0);
        chk(pin_out == 1, "R4 pin level held", pin_out, 1);
        chk(obs_ip == 2, "R2 period strobes, period 5", obs_ip, 2);

        // match equals period
        wreg(0, 4); wreg(1, 4);
        ctrl(1, 1, 0, 0, 0);
        clear_obs();
        run_ticks(12, 0);
        chk(obs_both == 3, "R5 match coincides with restart", obs_both, 3);
        chk(obs_tog == 3, "R5 toggles at restart", obs_tog, 3);

        // zero period
        wreg(0, 0);
        ctrl(1, 1, 0, 1, 0);
        clear_obs();
        run_ticks(10, 0);
        chk(obs_ip == 0 && obs_im == 0, "R6 strobes with zero period", obs_ip + obs_im, 0);
        chk(obs_tog == 0 && pin_out == 1, "R6 pin frozen", obs_tog, 0);

        // deferred reload across a mid-period write
        wreg(0, 6); wreg(1, 0);
        ctrl(1, 1, 0, 0, 0);
        run_ticks(3, 0);
        wreg(0, 3);
        wait_evt(0, 50, k);
        chk(k == 3, "R7 old period completes after write", k, 3);
        wait_evt(0, 50, k);
        chk(k == 3, "R7 new period after reload", k, 3);

        // immediate reload across a mid-period write
        ctrl(1, 1, 1, 0, 0);
        wreg(0, 6);
        run_ticks(2, 0);
        wreg(0, 4);
        wait_evt(0, 50, k);
        chk(k == 2, "R8 new period used at once", k, 2);

        // start level on clear
        ctrl(0, 1, 0, 1, 0);
        chk(pin_out == 1, "R9 pin takes start level 1", pin_out, 1);
        ctrl(0, 1, 0, 0, 0);
        chk(pin_out == 0, "R9 pin takes start level 0", pin_out, 0);

        // one-shot
        wreg(0, 3); wreg(1, 1);
        ctrl(1, 1, 0, 0, 1);
        clear_obs();
        run_ticks(10, 0);
        chk(obs_ip == 1, "R10 single period strobe", obs_ip, 1);
        chk(obs_im == 1 && obs_tog == 1, "R10 single match", obs_im, 1);
        ctrl(1, 1, 0, 0, 1);
        clear_obs();
        run_ticks(6, 0);
        chk(obs_ip == 1, "R10 restart runs one more period", obs_ip, 1);

        // clear beats a tick in the same cycle
        wreg(0, 3); wreg(1, 0);
        ctrl(1, 1, 0, 0, 0);
        run_ticks(2, 0);
        step(1, 2, 3, 1);
        wait_evt(0, 50, k);
        chk(k == 3, "R12 tick lost to clear", k, 3);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule